// File: doc/BRIEF.md
# Masked Exclusive Prefix Popcount Unit

This unit takes a bit vector of up to `MAX_VL` elements and produces one count per element. Each count is the number of set source bits at lower element positions whose predicate bit is also set. The count for an element never includes that element's own bit. An element whose predicate bit is clear is not given a count. It is written back with the prior destination value supplied for it.

An operation begins with a one-cycle `start_i` pulse. On that cycle the unit captures the source bits, the predicate bits, the prior destination values and the requested length. It then emits one destination element per clock, in ascending order from element 0, and raises `done_o` together with the last element.

Two mode inputs replace an operand with all ones. With `src_ones_i` set, every source bit counts as set, so the output for active elements is their rank among active elements. With the predicate also all ones, the output is the sequence 0, 1, 2, ..., length-1. With `pred_ones_i` set, every element is active.

Top module: `prefix_popcount_unit`

## Requirements
- R1: For an active element i, the written value is the number of positions j < i where both the source bit and the predicate bit are set. Bit i itself is never counted. Source 0x91 with all elements active and length 8 yields 0,1,1,1,1,2,2,2 for elements 0..7.
- R2: An element whose predicate bit is clear is written with its prior value, taken from `prior_i[i*CNT_W +: CNT_W]`, and does not add to later counts. Prior 9-i, predicate 0xEB, source 0x91 and length 8 give 0,1,7,1,5,1,1,1 for elements 0..7.
- R3: With `src_ones_i` high, every source bit is treated as set. With all elements active, element i is therefore written with i.
- R4: With `pred_ones_i` high, every element is active regardless of `pred_i`.
- R5: Element k of an operation is written with `wr_en_o` high and `wr_idx_o` = k, in the (k+2)-th cycle after the cycle in which `start_i` is accepted. Elements are written on consecutive cycles, each element exactly once.
- R6: `done_o` is a single-cycle pulse, high in the same cycle as the write of the last element. For a length of 0, it is high in the cycle after acceptance and no write takes place.
- R7: A requested length above `MAX_VL` is treated as `MAX_VL`.
- R8: A `start_i` that arrives while an operation is in progress is ignored. The running operation's results are unchanged.
- R9: After reset, `wr_en_o` and `done_o` are low until a start is accepted.
- R10: The running count restarts at zero for every operation, so back-to-back operations are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| len_i | input | LEN_W (7) | Requested element count, clamped to MAX_VL |
| src_i | input | MAX_VL (64) | Source bits, bit i for element i |
| src_ones_i | input | 1 | Treat the source as all ones |
| pred_i | input | MAX_VL (64) | Predicate bits, 1 = element active |
| pred_ones_i | input | 1 | Treat every element as active |
| prior_i | input | MAX_VL*CNT_W (448) | Prior destination values, element i at bits i*CNT_W +: CNT_W |
| wr_en_o | output | 1 | Destination element write strobe |
| wr_idx_o | output | IDX_W (6) | Index of the element being written |
| wr_data_o | output | CNT_W (7) | Value written to the element |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bench builds the unit with the default `MAX_VL` of 64. At that size the 7-bit length input can request up to 127 elements, so the clamp path is reachable. A full-length run of all-ones source and predicate drives the running count to its largest written value of 63. The bench mixes random lengths from 0 to 80, random operands and random mode bits with directed cases: the two worked examples, the zero and single-element lengths, and a start pulse issued during a busy operation.

// File: rtl/ppc_pkg.sv
// Package: shared helpers for the prefix popcount unit.
// Assumes lengths fit in 16 bits; callers truncate to their own width.
package ppc_pkg;

    // Clamp a requested length to the supported maximum.
    function automatic logic [15:0] clamp_len(input logic [15:0] req, input logic [15:0] max_len);
        return (req > max_len) ? max_len : req;
    endfunction

    // One element's operand bits as seen by the accumulator.
    typedef struct packed {
        logic src;
        logic act;
    } elem_bits_t;

endpackage

// File: rtl/ppc_sequencer.sv
// Module: ppc_sequencer
// Tracks the element index of a running operation. It accepts a start only
// when idle, clamps the length and produces a done pulse on the last element
// (or right away for a zero length).
// Assumes start_i is a synchronous level, sampled on each rising edge.
module ppc_sequencer #(
    parameter int MAX_VL = 64,
    parameter int IDX_W  = $clog2(MAX_VL),
    parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             accept_o,
    output logic             step_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [LEN_W-1:0] len_q_o,
    output logic             done_o
);
    import ppc_pkg::*;

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q;
    logic [LEN_W-1:0] len_eff;
    logic             last;

    // Clamp the requested length and decode the accept and last conditions.
    always_comb begin
        len_eff  = LEN_W'(clamp_len(16'(len_i), 16'(MAX_VL)));
        accept_o = start_i && !busy_q;
        last     = busy_q && (LEN_W'(idx_q) == (len_q - LEN_W'(1)));
    end

    // Index, busy flag and done pulse state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                len_q  <= len_eff;
                idx_q  <= '0;
                busy_q <= (len_eff != '0);
                done_q <= (len_eff == '0);
            end else if (busy_q) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    assign step_o  = busy_q;
    assign busy_o  = busy_q;
    assign idx_o   = idx_q;
    assign len_q_o = len_q;
    assign done_o  = done_q;
endmodule

// File: rtl/ppc_operand_latch.sv
// Module: ppc_operand_latch
// Captures the source, predicate and prior values when a start is accepted,
// applying the all-ones modes, and presents the operands of the current element.
// Assumes idx_i is below MAX_VL.
module ppc_operand_latch #(
    parameter int MAX_VL = 64,
    parameter int IDX_W  = $clog2(MAX_VL),
    parameter int CNT_W  = $clog2(MAX_VL + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept_i,
    input  logic [MAX_VL-1:0]       src_i,
    input  logic                    src_ones_i,
    input  logic [MAX_VL-1:0]       pred_i,
    input  logic                    pred_ones_i,
    input  logic [MAX_VL*CNT_W-1:0] prior_i,
    input  logic [IDX_W-1:0]        idx_i,
    output ppc_pkg::elem_bits_t     bits_o,
    output logic [CNT_W-1:0]        prior_o
);
    logic [MAX_VL-1:0] src_q;
    logic [MAX_VL-1:0] pred_q;
    logic [CNT_W-1:0]  prior_q [MAX_VL];

    // Capture the bit vectors with the all-ones modes folded in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            pred_q <= '0;
        end else if (accept_i) begin
            src_q  <= src_ones_i  ? '1 : src_i;
            pred_q <= pred_ones_i ? '1 : pred_i;
        end
    end

    // One prior-value register per element.
    for (genvar g = 0; g < MAX_VL; g++) begin : g_prior
        always_ff @(posedge clk) begin
            if (!rst_n) prior_q[g] <= '0;
            else if (accept_i) prior_q[g] <= prior_i[g*CNT_W +: CNT_W];
        end
    end

    // Present the operands of the element being processed.
    always_comb begin
        bits_o.src = src_q[idx_i];
        bits_o.act = pred_q[idx_i];
        prior_o    = prior_q[idx_i];
    end
endmodule

// File: rtl/ppc_accumulator.sv
// Module: ppc_accumulator
// Holds the running count of active set bits and registers one destination
// write per step: the count before this element if active, else the prior value.
// Assumes accept_i and step_i are never high together.
module ppc_accumulator #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic                step_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  ppc_pkg::elem_bits_t bits_i,
    input  logic [CNT_W-1:0]    prior_i,
    output logic [CNT_W-1:0]    run_cnt_o,
    output logic                wr_en_o,
    output logic [IDX_W-1:0]    wr_idx_o,
    output logic [CNT_W-1:0]    wr_data_o
);
    logic [CNT_W-1:0] cnt_q;

    // Running count: cleared on accept, bumped by each active set bit.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (accept_i) cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + CNT_W'(bits_i.src & bits_i.act);
    end

    // Registered destination write for the current element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= step_i;
            if (step_i) begin
                wr_idx_o  <= idx_i;
                wr_data_o <= bits_i.act ? cnt_q : prior_i;
            end
        end
    end

    assign run_cnt_o = cnt_q;
endmodule

// File: rtl/prefix_popcount_unit.sv
// Module: prefix_popcount_unit
// Masked exclusive prefix popcount: one destination element per clock, each
// active element receiving the count of active set source bits below it.
// Assumes prior values and operands are valid in the cycle start_i is accepted.
module prefix_popcount_unit #(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = $clog2(MAX_VL + 1),
    localparam int CNT_W = LEN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [LEN_W-1:0]        len_i,
    input  logic [MAX_VL-1:0]       src_i,
    input  logic                    src_ones_i,
    input  logic [MAX_VL-1:0]       pred_i,
    input  logic                    pred_ones_i,
    input  logic [MAX_VL*CNT_W-1:0] prior_i,
    output logic                    wr_en_o,
    output logic [IDX_W-1:0]        wr_idx_o,
    output logic [CNT_W-1:0]        wr_data_o,
    output logic                    done_o
);
    logic                accept;
    logic                step;
    logic                busy;
    logic [IDX_W-1:0]    idx;
    logic [LEN_W-1:0]    len_q;
    ppc_pkg::elem_bits_t bits;
    logic [CNT_W-1:0]    prior_sel;
    logic [CNT_W-1:0]    run_cnt;

    // Element sequencing and done generation.
    ppc_sequencer #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .accept_o(accept), .step_o(step), .busy_o(busy), .idx_o(idx),
        .len_q_o(len_q), .done_o(done_o)
    );

    // Operand capture and per-element selection.
    ppc_operand_latch #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ops (
        .clk(clk), .rst_n(rst_n), .accept_i(accept),
        .src_i(src_i), .src_ones_i(src_ones_i),
        .pred_i(pred_i), .pred_ones_i(pred_ones_i),
        .prior_i(prior_i), .idx_i(idx), .bits_o(bits), .prior_o(prior_sel)
    );

    // Running count and destination write register.
    ppc_accumulator #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .step_i(step),
        .idx_i(idx), .bits_i(bits), .prior_i(prior_sel), .run_cnt_o(run_cnt),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o)
    );
endmodule

// File: rtl/ppc_checker.sv
// Module: ppc_checker
// Protocol and sequencing properties of the prefix popcount unit, bound to
// the top module. Assumes reset is held for at least one clock.
module ppc_checker #(
    parameter int IDX_W = 6,
    parameter int LEN_W = 7,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [CNT_W-1:0] run_cnt,
    input logic [LEN_W-1:0] len_q,
    input logic             wr_en_o,
    input logic [IDX_W-1:0] wr_idx_o,
    input logic             done_o
);
    // R5: consecutive writes step the index by one.
    a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o == $past(wr_idx_o) + IDX_W'(1)));

    // R5: a write burst starts at element 0.
    a_r5_first_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en_o) |-> (wr_idx_o == '0));

    // R1: the running count grows by at most one per element.
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ((run_cnt == $past(run_cnt)) || (run_cnt == $past(run_cnt) + CNT_W'(1))));

    // R6: done appears only once the operation has left the busy state.
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    // R7: every written index lies inside the clamped length.
    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (LEN_W'(wr_idx_o) < len_q));
endmodule

bind prefix_popcount_unit ppc_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .run_cnt(run_cnt), .len_q(len_q),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .done_o(done_o)
);

// File: tb/test_prefix_popcount_unit.sv
module test_prefix_popcount_unit;
    localparam int MAXV = 64;
    localparam int CW   = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [6:0]       len_i = '0;
    logic [MAXV-1:0]  src_i = '0;
    logic             src_ones_i = 1'b0;
    logic [MAXV-1:0]  pred_i = '0;
    logic             pred_ones_i = 1'b0;
    logic [MAXV*CW-1:0] prior_i = '0;
    logic             wr_en_o;
    logic [5:0]       wr_idx_o;
    logic [CW-1:0]    wr_data_o;
    logic             done_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [CW-1:0] prior_a [MAXV];

    prefix_popcount_unit #(.MAX_VL(MAXV)) i_prefix_popcount_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .src_i(src_i), .src_ones_i(src_ones_i), .pred_i(pred_i),
        .pred_ones_i(pred_ones_i), .prior_i(prior_i), .wr_en_o(wr_en_o),
        .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .done_o(done_o)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Watchdog: a hung run is reported as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "WD", "watchdog expired", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // One operation: drive, collect writes, compare against the model.
    task automatic run_op(input logic [MAXV-1:0] s, input bit s_all,
                          input logic [MAXV-1:0] m, input bit m_all,
                          input int len, input bit noisy, input string tag);
        int eff, cnt, nwr, first_cyc, bad_idx;
        bit order_ok, done_seen, done_ok;
        logic [CW-1:0] exp_v [MAXV];
        logic [CW-1:0] got_v [MAXV];
        eff = (len > MAXV) ? MAXV : len;
        cnt = 0;
        for (int i = 0; i < MAXV; i++) begin
            got_v[i] = 'x;
            exp_v[i] = '0;
        end
        for (int i = 0; i < eff; i++) begin
            bit sb, mb;
            sb = s_all ? 1'b1 : s[i];
            mb = m_all ? 1'b1 : m[i];
            exp_v[i] = mb ? CW'(cnt) : prior_a[i];
            if (sb && mb) cnt++;
        end
        for (int i = 0; i < MAXV; i++) prior_i[i*CW +: CW] = prior_a[i];
        src_i = s; src_ones_i = s_all; pred_i = m; pred_ones_i = m_all;
        len_i = 7'(len); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (noisy) begin
            start_i = 1'b1; src_i = ~s; pred_i = ~m; len_i = 7'd3;
            for (int i = 0; i < MAXV; i++) prior_i[i*CW +: CW] = ~prior_a[i];
        end
        nwr = 0; first_cyc = -1; order_ok = 1'b1; done_seen = 1'b0; done_ok = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (c == 1) start_i = 1'b0;
            if (wr_en_o) begin
                if (first_cyc < 0) first_cyc = c;
                if (int'(wr_idx_o) != nwr) order_ok = 1'b0;
                got_v[wr_idx_o] = wr_data_o;
                nwr++;
            end
            if (done_o) begin
                done_seen = 1'b1;
                done_ok = (eff == 0) ? (!wr_en_o && nwr == 0)
                                     : (wr_en_o && int'(wr_idx_o) == eff - 1);
                break;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        bad_idx = -1;
        for (int i = 0; i < eff; i++)
            if (bad_idx < 0 && got_v[i] !== exp_v[i]) bad_idx = i;
        check(bad_idx < 0, tag, $sformatf("element %0d value", bad_idx),
              (bad_idx < 0) ? 0 : longint'(got_v[bad_idx]),
              (bad_idx < 0) ? 0 : longint'(exp_v[bad_idx]));
        check(order_ok && nwr == eff && (eff == 0 || first_cyc == 1), "R5",
              "write count/order/first cycle", nwr, eff);
        check(done_seen && done_ok, "R6", "done alignment", done_seen, 1);
        @(negedge clk);
        check(!done_o && !wr_en_o, "R6", "done is a single pulse", done_o, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < MAXV; i++) prior_a[i] = '0;
        repeat (3) @(negedge clk);
        check(wr_en_o == 1'b0, "R9", "wr_en after reset", wr_en_o, 0);
        check(done_o == 1'b0, "R9", "done after reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_en_o == 1'b0 && done_o == 1'b0, "R9", "idle without start", wr_en_o, 0);

        // R1: first worked example, all elements active.
        run_op(64'h91, 1'b0, '0, 1'b1, 8, 1'b0, "R1");
        // R2: disabled elements keep prior values 9-i.
        for (int i = 0; i < MAXV; i++) prior_a[i] = CW'((i < 8) ? 9 - i : 0);
        run_op(64'h91, 1'b0, 64'hEB, 1'b0, 8, 1'b0, "R2");
        // R3: all-ones source and predicate give the index sequence.
        run_op('0, 1'b1, '0, 1'b1, 64, 1'b0, "R3");
        // R3: all-ones source under a random predicate.
        for (int i = 0; i < MAXV; i++) prior_a[i] = CW'($urandom);
        run_op('0, 1'b1, {$urandom, $urandom}, 1'b0, 40, 1'b0, "R3");
        // R4: all-active mode ignores a zero predicate vector.
        run_op({$urandom, $urandom}, 1'b0, '0, 1'b1, 33, 1'b0, "R4");
        // R6: zero length and single element.
        run_op({$urandom, $urandom}, 1'b0, '1, 1'b0, 0, 1'b0, "R6");
        run_op('1, 1'b0, '1, 1'b0, 1, 1'b0, "R6");
        // R7: over-long request clamps to 64.
        run_op({$urandom, $urandom}, 1'b0, {$urandom, $urandom}, 1'b0, 100, 1'b0, "R7");
        // R8: a start during a busy operation changes nothing.
        for (int i = 0; i < MAXV; i++) prior_a[i] = CW'($urandom);
        run_op({$urandom, $urandom}, 1'b0, {$urandom, $urandom}, 1'b0, 20, 1'b1, "R8");

        // R10: back-to-back random operations, count restarts each time.
        for (int k = 0; k < 30; k++) begin
            for (int i = 0; i < MAXV; i++) prior_a[i] = CW'($urandom);
            run_op({$urandom, $urandom}, ($urandom % 6) == 0,
                   {$urandom, $urandom}, ($urandom % 4) == 0,
                   int'($urandom % 81), 1'b0, "R10");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule